// File: doc/BRIEF.md
# Self-Clocked Serial ADC Receiver

This block is the host side of a link to a successive-approximation converter. The converter returns its result on a single serial data line and sends no clock back. The receiver raises the convert strobe for a fixed number of cycles. It then waits out the converter's MSB-ready delay and drives a burst of serial clocks. While the burst runs, it samples the returning data line at three points spread evenly across each serial-clock period. The board delay and the converter's output delay are unknown, so the data can arrive at any point in that period. The receiver finds the frame's leading marker in each of the three sample streams and uses those positions to pick the sampling point that lies farthest from a data transition.

Each frame on the line is a 0, then a 1 marker, then a 0, then the 16 result bits, most significant first. The serial clock rests high and falls once per bit. The multiphase sampling is modelled with sample enables taken from a system clock that runs six times faster than the serial clock. Boards with several converters place one receiver per converter. Each receiver then finds its own alignment.

Top module: `serial_adc_rx`

## Requirements
- R1: A high `start_i` while the receiver is idle starts exactly one conversion. A `start_i` pulse that arrives while a conversion is in progress has no effect.
- R2: `cnv_o` stays high for exactly `CNV_CYC` cycles (default 4) per conversion and then returns low.
- R3: `sclk_o` is high except during the burst. The burst is 18 serial-clock periods of 6 cycles each, and `sclk_o` is low for the first 3 cycles of each period.
- R4: The first falling edge of `sclk_o` comes exactly `CNV_CYC + MSB_CYC` cycles (default 14) after `cnv_o` rises.
- R5: Phase p samples `din_i` once per serial period at cycle offset 2p+1 (offsets 1, 3, 5) counted from the falling edge of `sclk_o`. Sampling runs for 19 periods, which leaves one period of slack for data that arrives late.
- R6: In each phase stream, the marker is the first 1 among the first two samples. Its sample time is 6·index + offset. The selected phase is the one whose marker sample time is the median of the three, and it is reported on `phase_o` (0, 1 or 2).
- R7: `data_o` holds the 16 samples of the selected phase that follow the marker 1 and the 0 after it, most significant bit first. The word is read as signed two's complement.
- R8: If any phase has no 1 within its first two samples, or has a 1 where the 0 after the marker should be, `frame_err_o` pulses for one cycle. In that case no valid word is produced and `phase_o` is unchanged.
- R9: The first good frame after reset sets the phase lock and updates `phase_o` but produces no `valid_o`.
- R10: For each later good frame, `valid_o` pulses for exactly one cycle with the new `data_o`.
- R11: `phase_chg_o` pulses together with `valid_o` when the newly selected phase differs from the locked one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 6x the serial clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| din_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert strobe |
| sclk_o | output | 1 | Burst serial clock, rests high |
| data_o | output | 16 | Signed result word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| frame_err_o | output | 1 | One-cycle strobe for a malformed frame |
| phase_chg_o | output | 1 | Selected phase changed on this word |
| phase_o | output | 2 | Currently locked sampling phase |

## Verification
The bench sweeps the data-line delay over every cycle offset within one serial period and sends boundary words at each delay. A receiver with a wrong sample offset, or one that takes the wrong median, would lock the wrong phase or return a word shifted by one bit. Error frames include a missing marker, a marker whose following bit is 1, and a data 1 that lies outside the marker search window. A receiver with a search window that is too wide would accept that last frame as good with garbage data. The bench also moves the delay between frames, where a missed or spurious phase-change strobe would show. It checks that the first word is dropped, that a start during a busy conversion is ignored, and the exact timing of the strobe and the burst edges.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT,
    ST_BURST,
    ST_EVAL
  } sadc_st_e;
endpackage

// File: rtl/sadc_timing.sv
`timescale 1ns/1ps
module sadc_timing import sadc_pkg::*; #(
  parameter int CNV_CYC = 4,
  parameter int MSB_CYC = 10,
  parameter int NCLK    = 18,
  parameter int NS      = 19,
  parameter int NPH     = 3,
  parameter int PH_STEP = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic           cnv_o,
  output logic           sclk_o,
  output logic [NPH-1:0] smp_en_o,
  output logic           eval_o
);
  localparam int DIV  = NPH * PH_STEP;
  localparam int HALF = DIV / 2;
  localparam int TW   = $clog2(CNV_CYC + MSB_CYC + 1);
  localparam int CW   = $clog2(DIV);
  localparam int PW   = $clog2(NS + 1);
  localparam logic [TW-1:0] CNV_LAST = TW'(CNV_CYC - 1);
  localparam logic [TW-1:0] MSB_LAST = TW'(MSB_CYC - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(HALF);
  localparam logic [PW-1:0] PER_LAST = PW'(NS - 1);
  localparam logic [PW-1:0] PER_CLK  = PW'(NCLK);

  sadc_st_e      st_q;
  logic [TW-1:0] tcnt_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      cnt_q  <= '0;
      per_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_CNV;
          tcnt_q <= '0;
        end
        ST_CNV: if (tcnt_q == CNV_LAST) begin
          st_q   <= ST_WAIT;
          tcnt_q <= '0;
        end else tcnt_q <= tcnt_q + 1'b1;
        ST_WAIT: if (tcnt_q == MSB_LAST) begin
          st_q  <= ST_BURST;
          cnt_q <= '0;
          per_q <= '0;
        end else tcnt_q <= tcnt_q + 1'b1;
        ST_BURST: if (cnt_q == CNT_LAST) begin
          cnt_q <= '0;
          if (per_q == PER_LAST) st_q <= ST_EVAL;
          else per_q <= per_q + 1'b1;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o  = (st_q == ST_CNV);
  assign sclk_o = !((st_q == ST_BURST) && (per_q < PER_CLK) && (cnt_q < CNT_HALF));
  assign eval_o = (st_q == ST_EVAL);

  for (genvar p = 0; p < NPH; p++) begin : g_en
    assign smp_en_o[p] = (st_q == ST_BURST) && (cnt_q == CW'(p * PH_STEP + PH_STEP / 2));
  end
endmodule

// File: rtl/sadc_phase_cap.sv
`timescale 1ns/1ps
module sadc_phase_cap #(
  parameter int NS   = 19,
  parameter int LAGW = 2,
  parameter int PW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          din_i,
  output logic [NS-1:0] stream_o,
  output logic [PW-1:0] pos_o,
  output logic          hdr_ok_o
);
  logic found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stream_o <= '0;
    else if (en_i) stream_o <= {stream_o[NS-2:0], din_i};
  end

  // oldest sample sits at NS-1; earliest 1 in the search window wins
  always_comb begin
    found = 1'b0;
    pos_o = '0;
    for (int j = LAGW - 1; j >= 0; j--) begin
      if (stream_o[NS-1-j]) begin
        found = 1'b1;
        pos_o = PW'(j);
      end
    end
    hdr_ok_o = found && !stream_o[NS-2-int'(pos_o)];
  end
endmodule

// File: rtl/sadc_select.sv
`timescale 1ns/1ps
module sadc_select #(
  parameter int NPH     = 3,
  parameter int NS      = 19,
  parameter int PW      = 5,
  parameter int DW      = 16,
  parameter int HL      = 2,
  parameter int PH_STEP = 2,
  parameter int SW      = 2
) (
  input  logic [NPH-1:0][NS-1:0] streams_i,
  input  logic [NPH-1:0][PW-1:0] pos_i,
  output logic [SW-1:0]          sel_o,
  output logic [DW-1:0]          word_o
);
  localparam int DIV = NPH * PH_STEP;

  int key [NPH];
  int lt;
  int psel;

  always_comb begin
    for (int p = 0; p < NPH; p++)
      key[p] = int'(pos_i[p]) * DIV + p * PH_STEP + PH_STEP / 2;
    sel_o = '0;
    for (int p = 0; p < NPH; p++) begin
      lt = 0;
      for (int q = 0; q < NPH; q++)
        if (key[q] < key[p]) lt++;
      if (lt == NPH / 2) sel_o = SW'(p);
    end
    psel = int'(pos_i[sel_o]);
    for (int i = 0; i < DW; i++)
      word_o[DW-1-i] = streams_i[sel_o][NS-1-(psel+HL+i)];
  end
endmodule

// File: rtl/serial_adc_rx.sv
`timescale 1ns/1ps
module serial_adc_rx #(
  parameter int DW      = 16,
  parameter int NPH     = 3,
  parameter int PH_STEP = 2,
  parameter int CNV_CYC = 4,
  parameter int MSB_CYC = 10,
  parameter int LAG_MAX = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 din_i,
  output logic                 cnv_o,
  output logic                 sclk_o,
  output logic signed [DW-1:0] data_o,
  output logic                 valid_o,
  output logic                 frame_err_o,
  output logic                 phase_chg_o,
  output logic [1:0]           phase_o
);
  localparam int HL   = 2;
  localparam int NCLK = DW + HL;
  localparam int NS   = NCLK + LAG_MAX;
  localparam int LAGW = LAG_MAX + 1;
  localparam int PW   = $clog2(NS + 1);
  localparam int SW   = 2;

  logic [NPH-1:0]          smp_en;
  logic                    eval;
  logic [NPH-1:0][NS-1:0]  streams;
  logic [NPH-1:0][PW-1:0]  pos;
  logic [NPH-1:0]          hdr_ok;
  logic [SW-1:0]           sel;
  logic [DW-1:0]           word;
  logic                    locked_q;

  sadc_timing #(
    .CNV_CYC(CNV_CYC), .MSB_CYC(MSB_CYC), .NCLK(NCLK), .NS(NS),
    .NPH(NPH), .PH_STEP(PH_STEP)
  ) u_timing (
    .clk_i, .rst_ni, .start_i,
    .cnv_o, .sclk_o,
    .smp_en_o(smp_en),
    .eval_o(eval)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    sadc_phase_cap #(.NS(NS), .LAGW(LAGW), .PW(PW)) u_cap (
      .clk_i, .rst_ni,
      .en_i(smp_en[p]),
      .din_i,
      .stream_o(streams[p]),
      .pos_o(pos[p]),
      .hdr_ok_o(hdr_ok[p])
    );
  end

  sadc_select #(
    .NPH(NPH), .NS(NS), .PW(PW), .DW(DW), .HL(HL), .PH_STEP(PH_STEP), .SW(SW)
  ) u_sel (
    .streams_i(streams),
    .pos_i(pos),
    .sel_o(sel),
    .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q    <= 1'b0;
      phase_o     <= '0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      phase_chg_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      phase_chg_o <= 1'b0;
      if (eval) begin
        if (!(&hdr_ok)) begin
          frame_err_o <= 1'b1;
        end else begin
          phase_o  <= sel;
          locked_q <= 1'b1;
          if (locked_q) begin
            valid_o     <= 1'b1;
            data_o      <= word;
            phase_chg_o <= (sel != phase_o);
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_adc_rx_chk.sv
`timescale 1ns/1ps
module serial_adc_rx_chk #(
  parameter int CNV_CYC = 4,
  parameter int NCLK    = 18
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cnv_o,
  input logic       sclk_o,
  input logic       valid_o,
  input logic       frame_err_o,
  input logic       phase_chg_o,
  input logic [1:0] phase_o
);
  logic [7:0] hcnt_q;
  logic [7:0] fcnt_q;
  logic       sclk_q;
  logic       cnv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      fcnt_q <= '0;
      sclk_q <= 1'b1;
      cnv_q  <= 1'b0;
    end else begin
      hcnt_q <= cnv_o ? hcnt_q + 1'b1 : '0;
      sclk_q <= sclk_o;
      cnv_q  <= cnv_o;
      if (cnv_o && !cnv_q)        fcnt_q <= '0;
      else if (sclk_q && !sclk_o) fcnt_q <= fcnt_q + 1'b1;
    end
  end

  AST_CNV_MAX_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_o |-> (hcnt_q < 8'(CNV_CYC))); // R2
  AST_CNV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_q && !cnv_o) |-> (hcnt_q == 8'(CNV_CYC))); // R2
  AST_SCLK_REST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_o |-> sclk_o); // R3
  AST_FALL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_q <= 8'(NCLK)); // R4
  AST_FALLS_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_o && !cnv_q) |-> (fcnt_q == 8'd0 || fcnt_q == 8'(NCLK))); // R4
  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3); // R6
  AST_ERR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !valid_o); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R10
  AST_CHG_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_chg_o |-> valid_o); // R11
endmodule

bind serial_adc_rx serial_adc_rx_chk #(.CNV_CYC(CNV_CYC), .NCLK(NCLK)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnv_o(cnv_o), .sclk_o(sclk_o),
  .valid_o(valid_o), .frame_err_o(frame_err_o), .phase_chg_o(phase_chg_o),
  .phase_o(phase_o)
);

// File: tb/serial_adc_rx_tb_top.sv
`timescale 1ns/1ps
module serial_adc_rx_tb_top;
  localparam int CNV   = 4;
  localparam int MSB   = 10;
  localparam int DIV   = 6;
  localparam int NCLK  = 18;
  localparam int NS    = 19;
  localparam int FRAME = CNV + MSB + NS * DIV + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic din = 1'b0;
  logic cnv, sclk, valid, ferr, pchg;
  logic signed [15:0] data;
  logic [1:0] phase;

  always #2.5 clk = ~clk;

  serial_adc_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .din_i(din),
    .cnv_o(cnv), .sclk_o(sclk), .data_o(data), .valid_o(valid),
    .frame_err_o(ferr), .phase_chg_o(pchg), .phase_o(phase)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // converter model and port monitor
  logic [17:0] frm = '0;
  int dly = 0;
  int cyc = 0, fall_n = 0;
  int ft [18];
  logic p_cnv = 1'b0, p_sclk = 1'b1;
  int n_rise, cnv_len, n_falls, t_rise, t_fall, n_val, n_err, n_chg;
  logic [15:0] got;
  logic [1:0] gph;

  initial begin
    forever begin
      int k;
      @(negedge clk);
      cyc++;
      if (cnv && !p_cnv) begin n_rise++; t_rise = cyc; fall_n = 0; end
      if (cnv) cnv_len++;
      if (!sclk && p_sclk) begin
        if (fall_n < 18) ft[fall_n] = cyc;
        if (n_falls == 0) t_fall = cyc;
        fall_n++;
        n_falls++;
      end
      k = 0;
      for (int i = 0; i < fall_n && i < 18; i++) if (ft[i] + dly <= cyc) k++;
      din = (k == 0) ? 1'b0 : frm[18-k];
      if (valid) begin n_val++; got = data; gph = phase; end
      if (ferr) n_err++;
      if (pchg) n_chg++;
      p_cnv = cnv;
      p_sclk = sclk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_phase(input int d);
    int key [3];
    int lt;
    for (int p = 0; p < 3; p++) begin
      int o = 2 * p + 1;
      key[p] = ((o >= d) ? 0 : 1) * DIV + o;
    end
    for (int p = 0; p < 3; p++) begin
      lt = 0;
      for (int q = 0; q < 3; q++) if (key[q] < key[p]) lt++;
      if (lt == 1) return p;
    end
    return -1;
  endfunction

  bit locked = 0;
  int prev_ph = 0;

  task automatic run(input logic [15:0] w, input int d, input logic [1:0] hdr, input bit extra);
    int ep;
    @(negedge clk); #1;
    frm = {hdr, w}; dly = d;
    n_rise = 0; cnv_len = 0; n_falls = 0; n_val = 0; n_err = 0; n_chg = 0;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (extra) begin
      repeat (40) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
      repeat (FRAME - 36) @(negedge clk);
    end else begin
      repeat (FRAME + 6) @(negedge clk);
    end
    #1;
    chk("R1 one conversion per start", n_rise, 1);
    chk("R2 cnv high cycles", cnv_len, CNV);
    chk("R3 sclk falls per burst", n_falls, NCLK);
    chk("R4 cnv rise to first sclk fall", t_fall - t_rise, CNV + MSB);
    ep = exp_phase(d);
    if (hdr == 2'b10) begin
      chk("R5 R6 selected phase", int'(phase), ep);
      chk("R8 no frame error on good frame", n_err, 0);
      if (!locked) begin
        chk("R9 first word discarded", n_val, 0);
        locked = 1;
      end else begin
        chk("R10 one valid strobe", n_val, 1);
        chk("R7 data word", int'(got), int'(w));
        chk("R7 signed view", int'($signed(got) < 0), int'(w[15]));
        chk("R6 phase at valid", int'(gph), ep);
        chk("R11 phase change strobe", n_chg, (ep != prev_ph) ? 1 : 0);
      end
      prev_ph = ep;
    end else begin
      chk("R8 frame error strobe", n_err, 1);
      chk("R8 no valid on bad frame", n_val, 0);
      chk("R8 phase held on bad frame", int'(phase), prev_ph);
    end
  endtask

  logic [15:0] pats [8] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF,
                            16'h0001, 16'h8001, 16'hA5C3, 16'h3C5A};

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 cnv low in reset", int'(cnv), 0);
    chk("R3 sclk high in reset", int'(sclk), 1);
    chk("R10 valid low in reset", int'(valid), 0);
    chk("R8 frame error low in reset", int'(ferr), 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 sclk rests high", int'(sclk), 1);
    // R9: first frame locks only
    run(16'h1234, 0, 2'b10, 0);
    for (int d = 0; d < 6; d++)
      for (int p = 0; p < 8; p++)
        run(pats[p], d, 2'b10, (d == 2 && p == 3));
    // R8: marker missing, marker followed by 1, data 1 outside window
    run(16'h0000, 4, 2'b00, 0);
    run(16'h1111, 4, 2'b11, 0);
    run(16'h4000, 1, 2'b00, 0);
    // R11: good frame after errors at the same delay, then phase moves
    run(16'h0F0F, 5, 2'b10, 0);
    run(16'hF0F0, 0, 2'b10, 0);
    run(16'h00FF, 3, 2'b10, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule